// File: doc/BRIEF.md
# DAC Output Update Controller

This block decides when a code written over the register interface reaches a channel's active output register. Each channel holds an active code and a one-entry pending buffer. A channel in immediate mode copies a write into its active register on the next clock edge. A channel in synchronous mode keeps the written code in its buffer. It moves that code to the output only when a load strobe arrives. A load strobe comes from a falling edge on the external load pin or from a pulse on the software trigger bit.

A broadcast write carries one code for every channel. Only channels that have opted in take it, and each of those applies it under its own update mode. A clear request forces each channel to zero-scale or to mid-scale, as chosen by that channel's own select bit. The clear also drops any code that is waiting in the buffer.

Top module: `dac_update_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every channel output is 0x000 and no code is pending.
- R2: With its sync bit at 0, a channel shows a written code on the clock edge that samples the write strobe.
- R3: With its sync bit at 1, a written code leaves the output unchanged until a load strobe arrives.
- R4: A falling edge of the load pin (active low, idle high) passes through two synchronizer flops. A pending code reaches the output on the third rising clock edge after the pin goes low. A rising edge of the pin has no effect.
- R5: A one-cycle pulse on the software trigger input sets a trigger bit on the next edge. That bit clears itself one cycle later, and the pending code reaches the output one edge after the bit is set. A load strobe with nothing pending leaves the output unchanged.
- R6: A broadcast write is taken only by channels whose broadcast-enable bit is 1, and each such channel applies it under its own sync mode. Channels whose bit is 0 keep their output and buffer.
- R7: If a direct write and a broadcast write hit the same channel in one cycle, the direct write's code is used.
- R8: A clear request drives a channel to 0x000 when its clear-select bit is 0, and to mid-scale 0x800 when it is 1, on the next edge.
- R9: A clear takes priority over a load strobe and over a write in the same cycle, and it discards the pending code, so a later load strobe leaves the clear value in place.
- R10: When a load strobe and a synchronous write coincide, the previously pending code is transferred and the new code becomes the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_clr_mid_i | input | NUM_CH | Per channel: 1 clears to mid-scale, 0 to zero-scale |
| cfg_sync_i | input | NUM_CH | Per channel: 1 holds writes for a load strobe, 0 updates at once |
| cfg_bcast_en_i | input | NUM_CH | Per channel: 1 accepts broadcast writes |
| wr_en_i | input | 1 | Direct write strobe |
| wr_ch_i | input | CH_W | Channel addressed by the direct write |
| wr_code_i | input | CODE_W | Code of the direct write |
| bc_wr_i | input | 1 | Broadcast write strobe |
| bc_code_i | input | CODE_W | Code of the broadcast write |
| ldac_ni | input | 1 | Asynchronous load pin, acts on its falling edge |
| sw_trig_i | input | 1 | Software write of 1 to the trigger bit |
| clr_i | input | 1 | Clear request |
| out_code_o | output | NUM_CH*CODE_W | Active codes, channel c at bits c*CODE_W upward |

## Verification
The bench writes distinct codes to both channels in immediate mode and in synchronous mode. It checks the output at each edge of the load pin's synchronizer latency, so an early or late transfer is seen. The software trigger is tried both with a code pending and with nothing pending, which separates a real transfer from a stale one. Broadcasts are sent with mixed enable bits and mixed sync modes, and once together with a direct write. Clears are issued with both select values and are made to coincide with a load strobe and with a write, which tells clear priority apart from load priority and shows whether the buffer was discarded.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;
  localparam int unsigned DEF_CODE_W = 12;

  function automatic logic [31:0] clear_value(input int unsigned width, input logic mid);
    return mid ? (32'd1 << (width - 1)) : 32'd0;
  endfunction
endpackage

// File: rtl/dac_load_strobe.sv
module dac_load_strobe #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ldac_ni,
  input  logic sw_trig_i,
  output logic load_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic                 trig_q;
  logic                 fall_w;

  // top bit keeps the previous synchronized value for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ldac_ni};
  end

  // trigger bit: set by a write of 1, gone one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= sw_trig_i;
  end

  assign fall_w = sync_q[SYNC_STAGES] & ~sync_q[SYNC_STAGES-1];
  assign load_o = fall_w | trig_q;
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_upd_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              clr_mid_i,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] out_o
);
  localparam logic [CODE_W-1:0] ZERO_CODE = CODE_W'(clear_value(CODE_W, 1'b0));
  localparam logic [CODE_W-1:0] MID_CODE  = CODE_W'(clear_value(CODE_W, 1'b1));

  logic [CODE_W-1:0] act_q, buf_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      buf_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      act_q  <= clr_mid_i ? MID_CODE : ZERO_CODE;
      pend_q <= 1'b0;
    end else begin
      if (load_i && pend_q) begin
        act_q  <= buf_q;
        pend_q <= 1'b0;
      end
      if (hit_i) begin
        if (sync_i) begin
          buf_q  <= code_i;
          pend_q <= 1'b1;
        end else begin
          act_q  <= code_i;
        end
      end
    end
  end

  assign out_o = act_q;
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_upd_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        cfg_clr_mid_i,
  input  logic [NUM_CH-1:0]        cfg_sync_i,
  input  logic [NUM_CH-1:0]        cfg_bcast_en_i,
  input  logic                     wr_en_i,
  input  logic [CH_W-1:0]          wr_ch_i,
  input  logic [CODE_W-1:0]        wr_code_i,
  input  logic                     bc_wr_i,
  input  logic [CODE_W-1:0]        bc_code_i,
  input  logic                     ldac_ni,
  input  logic                     sw_trig_i,
  input  logic                     clr_i,
  output logic [NUM_CH*CODE_W-1:0] out_code_o
);
  logic load_w;

  dac_load_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_load (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ldac_ni  (ldac_ni),
    .sw_trig_i(sw_trig_i),
    .load_o   (load_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              dir_hit, bc_hit;
    logic [CODE_W-1:0] code_w;

    assign dir_hit = wr_en_i && (wr_ch_i == CH_W'(c));
    assign bc_hit  = bc_wr_i && cfg_bcast_en_i[c];
    // direct write wins over broadcast
    assign code_w  = dir_hit ? wr_code_i : bc_code_i;

    dac_chan #(.CODE_W(CODE_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sync_i   (cfg_sync_i[c]),
      .clr_mid_i(cfg_clr_mid_i[c]),
      .clr_i    (clr_i),
      .load_i   (load_w),
      .hit_i    (dir_hit | bc_hit),
      .code_i   (code_w),
      .out_o    (out_code_o[c*CODE_W +: CODE_W])
    );
  end
endmodule

module dac_update_ctrl_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned CH_W   = 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_CH-1:0]        cfg_clr_mid_i,
  input logic [NUM_CH-1:0]        cfg_sync_i,
  input logic [NUM_CH-1:0]        cfg_bcast_en_i,
  input logic                     wr_en_i,
  input logic [CH_W-1:0]          wr_ch_i,
  input logic [CODE_W-1:0]        wr_code_i,
  input logic                     bc_wr_i,
  input logic                     sw_trig_i,
  input logic                     clr_i,
  input logic                     load_w,
  input logic [NUM_CH*CODE_W-1:0] out_code_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  a_r1_reset_zero: assert property (@(posedge clk_i) !rst_ni |-> out_code_o == '0);

  a_r5_trig_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_trig_i |=> load_w);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic dir_w, bc_w;
    assign dir_w = wr_en_i && (wr_ch_i == CH_W'(c));
    assign bc_w  = bc_wr_i && cfg_bcast_en_i[c];

    a_r8_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !cfg_clr_mid_i[c]) |=> out_code_o[c*CODE_W +: CODE_W] == '0);

    a_r8_clr_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && cfg_clr_mid_i[c]) |=> out_code_o[c*CODE_W +: CODE_W] == MID);

    a_r2_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dir_w && !cfg_sync_i[c] && !clr_i) |=> out_code_o[c*CODE_W +: CODE_W] == $past(wr_code_i));

    a_r7_direct_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dir_w && bc_w && !cfg_sync_i[c] && !clr_i) |=> out_code_o[c*CODE_W +: CODE_W] == $past(wr_code_i));

    a_r3_sync_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((dir_w || bc_w) && cfg_sync_i[c] && !clr_i && !load_w) |=> $stable(out_code_o[c*CODE_W +: CODE_W]));

    a_r6_bcast_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bc_wr_i && !cfg_bcast_en_i[c] && !dir_w && !clr_i && !load_w) |=> $stable(out_code_o[c*CODE_W +: CODE_W]));
  end
endmodule

bind dac_update_ctrl dac_update_ctrl_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .CH_W(CH_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_clr_mid_i (cfg_clr_mid_i),
  .cfg_sync_i    (cfg_sync_i),
  .cfg_bcast_en_i(cfg_bcast_en_i),
  .wr_en_i       (wr_en_i),
  .wr_ch_i       (wr_ch_i),
  .wr_code_i     (wr_code_i),
  .bc_wr_i       (bc_wr_i),
  .sw_trig_i     (sw_trig_i),
  .clr_i         (clr_i),
  .load_w        (load_w),
  .out_code_o    (out_code_o)
);

// File: tb/dac_update_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_update_ctrl_tb_top;
  localparam int NC = 2;
  localparam int W  = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NC-1:0] cfg_clr_mid_i = '0, cfg_sync_i = '0, cfg_bcast_en_i = '0;
  logic          wr_en_i = 1'b0;
  logic [0:0]    wr_ch_i = '0;
  logic [W-1:0]  wr_code_i = '0, bc_code_i = '0;
  logic          bc_wr_i = 1'b0, ldac_ni = 1'b1, sw_trig_i = 1'b0, clr_i = 1'b0;
  logic [NC*W-1:0] out_code_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int           ch;
    logic [W-1:0] val;
    string        req;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk_i = ~clk_i;

  dac_update_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_clr_mid_i(cfg_clr_mid_i), .cfg_sync_i(cfg_sync_i),
    .cfg_bcast_en_i(cfg_bcast_en_i), .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i), .wr_code_i(wr_code_i),
    .bc_wr_i(bc_wr_i), .bc_code_i(bc_code_i), .ldac_ni(ldac_ni), .sw_trig_i(sw_trig_i),
    .clr_i(clr_i), .out_code_o(out_code_o)
  );

  task automatic step(); @(negedge clk_i); endtask

  task automatic expect_out(input int ch, input logic [W-1:0] v, input string r);
    exp_t e;
    e.ch = ch; e.val = v; e.req = r;
    sb_q.push_back(e);
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        logic [W-1:0] act;
        e = sb_q.pop_front();
        act = out_code_o[e.ch*W +: W];
        checks++;
        if (act !== e.val) begin
          errors++;
          $display("FAIL %s ch%0d: actual %h expected %h", e.req, e.ch, act, e.val);
        end
      end
    end
  end

  task automatic write(input int ch, input logic [W-1:0] code);
    wr_en_i = 1'b1; wr_ch_i = 1'(ch); wr_code_i = code;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic bcast(input logic [W-1:0] code);
    bc_wr_i = 1'b1; bc_code_i = code;
    step();
    bc_wr_i = 1'b0;
  endtask

  task automatic trig();
    sw_trig_i = 1'b1;
    step();
    sw_trig_i = 1'b0;
    step();
  endtask

  initial begin
    step(); step();
    expect_out(0, 12'h000, "R1");
    step();
    rst_ni = 1'b1;
    step();
    expect_out(0, 12'h000, "R1"); expect_out(1, 12'h000, "R1");

    // R2 immediate
    write(0, 12'h123); expect_out(0, 12'h123, "R2");
    write(1, 12'hABC); expect_out(1, 12'hABC, "R2"); expect_out(0, 12'h123, "R2");

    // R3 sync hold
    cfg_sync_i[0] = 1'b1;
    write(0, 12'h456); expect_out(0, 12'h123, "R3");
    step(); step(); expect_out(0, 12'h123, "R3");

    // R4 load pin falling edge, three-edge latency
    ldac_ni = 1'b0;
    step(); expect_out(0, 12'h123, "R4");
    step(); expect_out(0, 12'h123, "R4");
    step(); expect_out(0, 12'h456, "R4");
    write(0, 12'h789);
    ldac_ni = 1'b1;
    step(); step(); step(); step(); expect_out(0, 12'h456, "R4");

    // R5 software trigger
    sw_trig_i = 1'b1; step(); sw_trig_i = 1'b0;
    expect_out(0, 12'h456, "R5");
    step(); expect_out(0, 12'h789, "R5");
    trig(); expect_out(0, 12'h789, "R5");

    // R6 broadcast enable and ignore
    cfg_bcast_en_i = 2'b10;
    bcast(12'h321); expect_out(1, 12'h321, "R6"); expect_out(0, 12'h789, "R6");
    step(); trig(); expect_out(0, 12'h789, "R6");
    cfg_bcast_en_i = 2'b11;
    bcast(12'h654); expect_out(1, 12'h654, "R6"); expect_out(0, 12'h789, "R6");
    trig(); expect_out(0, 12'h654, "R6");

    // R7 direct write beats broadcast
    wr_en_i = 1'b1; wr_ch_i = 1'b1; wr_code_i = 12'h111;
    bc_wr_i = 1'b1; bc_code_i = 12'h222;
    step();
    wr_en_i = 1'b0; bc_wr_i = 1'b0;
    expect_out(1, 12'h111, "R7"); expect_out(0, 12'h654, "R7");
    trig(); expect_out(0, 12'h222, "R7");

    // R8 clear scales
    cfg_clr_mid_i = 2'b10;
    clr_i = 1'b1; step(); clr_i = 1'b0;
    expect_out(0, 12'h000, "R8"); expect_out(1, 12'h800, "R8");
    cfg_clr_mid_i = 2'b01;
    clr_i = 1'b1; step(); clr_i = 1'b0;
    expect_out(0, 12'h800, "R8"); expect_out(1, 12'h000, "R8");

    // R9 clear beats coincident load and write, drops pending
    write(1, 12'h333); expect_out(1, 12'h333, "R9");
    write(0, 12'h5A5);
    sw_trig_i = 1'b1; step(); sw_trig_i = 1'b0;
    clr_i = 1'b1; wr_en_i = 1'b1; wr_ch_i = 1'b1; wr_code_i = 12'h777;
    step();
    clr_i = 1'b0; wr_en_i = 1'b0;
    expect_out(0, 12'h800, "R9"); expect_out(1, 12'h000, "R9");
    trig(); expect_out(0, 12'h800, "R9");

    // R10 load coincides with a new buffered write
    write(0, 12'h0F0);
    sw_trig_i = 1'b1; step(); sw_trig_i = 1'b0;
    wr_en_i = 1'b1; wr_ch_i = 1'b0; wr_code_i = 12'h0E0;
    step();
    wr_en_i = 1'b0;
    expect_out(0, 12'h0F0, "R10");
    trig(); expect_out(0, 12'h0E0, "R10");

    step(); step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule